// File: doc/BRIEF.md
# TDM Frame Sync and Slot Sequencer

This block paces a serial port's framing. It counts bits on a bit-clock strobe, groups them into words of a programmable length and groups words into frames. From that position it drives a transmit frame-sync pin, a receive frame-sync pin, a word-start marker and the current slot number. It also drives per-slot transmit and receive enables, a transmit tristate control, a transmit-underrun-check enable and two last-slot indications. The data shifters that use these controls sit next to it.

A single 5-bit rate field has three meanings. In normal mode it is the frame-to-word ratio minus one, and only the first word of each frame carries data. In network mode it is the slot count minus one, and a 32-bit mask for each direction picks the live slots. In network mode a value of zero selects on-demand operation, where a frame starts only after a word has been handed to the transmitter.

The sync shape is programmable. A sync can last one bit or a whole word, its polarity can be chosen, and a word sync can be moved one bit earlier. A one-shot null write silences the transmitter for the rest of the current slot.

Top module: `tdm_slot_sequencer`

## Requirements
- R1: Normal mode (`net_mode`=0). A frame is `word_len`×(`rate_field`+1) bits long. Only slot 0 is active for both directions, and the masks are ignored.
- R2: Network mode (`net_mode`=1, `rate_field`≥1). A frame holds `rate_field`+1 slots of `word_len` bits each. Slot n is active for transmit when `tx_mask[n]`=1 and for receive when `rx_mask[n]`=1.
- R3: On-demand mode (`net_mode`=1, `rate_field`=0) has no periodic sync and no active slot. A pulse on `tx_wr` makes the next word after the current one active, with its syncs and enables. `tx_urun_en` stays 0 throughout this mode.
- R4: `fs_len` selects the sync length per direction, with 1 meaning bit-length and 0 meaning word-length. The bit pair {receive, transmit} is: 0 → {0,0}, 1 → {0,1}, 2 → {1,1}, 3 → {1,0}.
- R5: A bit-length sync is active during the last bit before the frame. A word-length sync is active during the `word_len` bits of slot 0, or from that last bit up to the second-to-last bit of slot 0 when `fs_early`=1. `fs_early` does not change bit-length syncs.
- R6: With `fs_inv`=0 the sync pins are active-high. With `fs_inv`=1 they are active-low.
- R7: `tx_hiz` is 1 in every slot whose transmit enable is 0. Outside on-demand mode, `tx_urun_en` equals `tx_slot_en`.
- R8: A `null_wr` pulse raises `tx_hiz` from the next clock to the end of the current slot. The next slot is not affected, and `tx_slot_en` does not change.
- R9: In network mode, `tx_last_slot` is 1 during the first bit of the last slot. `rx_last_slot` is a one-clock pulse in the clock where `bit_en` accepts the final bit of the last slot.
- R10: `slot_idx` advances after every `word_len` accepted bits and wraps to 0 at each frame start. It holds while `bit_en` is 0.
- R11: `word_start` is 1 during the first bit of each word. In on-demand mode this applies only to active words.
- R12: After reset the position is bit 0 of slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit-clock strobe; each high clock accepts one bit |
| word_len | input | 6 | Bits per word, 2 to 32 |
| rate_field | input | 5 | Ratio / slot count minus one; 0 with net_mode selects on-demand |
| net_mode | input | 1 | 1 = network mode, 0 = normal mode |
| fs_len | input | 2 | Sync length code per R4 |
| fs_early | input | 1 | Move word-length syncs one bit earlier |
| fs_inv | input | 1 | 1 = active-low syncs |
| tx_mask | input | 32 | Transmit slot enables |
| rx_mask | input | 32 | Receive slot enables |
| tx_wr | input | 1 | Transmit word written (on-demand trigger) |
| null_wr | input | 1 | Silence transmit for the current slot |
| tx_fs | output | 1 | Transmit frame-sync pin level |
| rx_fs | output | 1 | Receive frame-sync pin level |
| word_start | output | 1 | First bit of a word |
| slot_idx | output | 5 | Current slot number |
| tx_slot_en | output | 1 | Transmit active in this slot (empty flag allowed) |
| rx_slot_en | output | 1 | Receive active in this slot (full/overrun flags allowed) |
| tx_hiz | output | 1 | Tristate the transmit data pin |
| tx_urun_en | output | 1 | Underrun checking allowed in this slot |
| tx_last_slot | output | 1 | First bit of the last slot |
| rx_last_slot | output | 1 | Final bit of the last slot is being accepted |

## Verification
Every output except `rx_last_slot` is decoded from registered counters and flags. Each of them is therefore due in the clock after the `bit_en`, `tx_wr` or `null_wr` edge that caused it. The bench raises each strobe for one clock and samples at the following falling edge. `rx_last_slot` depends on `bit_en` in the same clock, so the bench samples it while the strobe is still high, before the edge that accepts the bit. In on-demand mode the trigger is checked to take effect only at the next word boundary, and a null write is checked both one clock after the pulse and across the next slot boundary.

// File: rtl/tdm_seq_pkg.sv
package tdm_seq_pkg;

   typedef enum logic [1:0] {
      FSL_WORD_WORD = 2'd0,
      FSL_WORD_BIT  = 2'd1,
      FSL_BIT_BIT   = 2'd2,
      FSL_BIT_WORD  = 2'd3
   } fsl_code_e;

   // transmit side uses a one-bit sync for these codes
   function automatic logic tx_is_bit(input fsl_code_e c);
      return (c == FSL_WORD_BIT) || (c == FSL_BIT_BIT);
   endfunction

   // receive side uses a one-bit sync for these codes
   function automatic logic rx_is_bit(input fsl_code_e c);
      return (c == FSL_BIT_BIT) || (c == FSL_BIT_WORD);
   endfunction

endpackage

// File: rtl/tdm_bit_slot_counter.sv
module tdm_bit_slot_counter #(
   parameter int WL_W   = 6,
   parameter int SLOT_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic [WL_W-1:0]   word_len,
   input  logic [SLOT_W-1:0] slot_last_idx,
   output logic [WL_W-1:0]   bit_cnt,
   output logic [SLOT_W-1:0] slot_cnt,
   output logic              last_bit,
   output logic              last_slot
);

   logic [WL_W-1:0] wl_m1;

   assign wl_m1     = word_len - WL_W'(1);
   assign last_bit  = (bit_cnt >= wl_m1);
   assign last_slot = (slot_cnt >= slot_last_idx);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bit_cnt  <= '0;
         slot_cnt <= '0;
      end else if (bit_en) begin
         if (last_bit) begin
            bit_cnt  <= '0;
            slot_cnt <= last_slot ? '0 : slot_cnt + SLOT_W'(1);
         end else begin
            bit_cnt <= bit_cnt + WL_W'(1);
         end
      end
   end

endmodule

// File: rtl/tdm_frame_ctrl.sv
module tdm_frame_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   input  logic od_mode,
   input  logic frame_last,
   input  logic last_bit,
   input  logic tx_wr,
   input  logic null_wr,
   output logic od_pend,
   output logic od_act,
   output logic null_flag
);

   // on-demand trigger: a write arms the next word
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         od_pend <= 1'b0;
         od_act  <= 1'b0;
      end else if (!od_mode) begin
         od_pend <= 1'b0;
         od_act  <= 1'b0;
      end else if (bit_en && frame_last) begin
         od_act  <= od_pend;
         od_pend <= tx_wr;
      end else if (tx_wr) begin
         od_pend <= 1'b1;
      end
   end

   // null slot: a write wins over the slot-end clear
   always_ff @(posedge clk) begin
      if (!rst_n)
         null_flag <= 1'b0;
      else if (null_wr)
         null_flag <= 1'b1;
      else if (bit_en && last_bit)
         null_flag <= 1'b0;
   end

endmodule

// File: rtl/tdm_sync_gen.sv
module tdm_sync_gen
   import tdm_seq_pkg::*;
(
   input  logic      slot0,
   input  logic      last_bit,
   input  logic      frame_last,
   input  logic      od_mode,
   input  logic      od_pend,
   input  logic      od_act,
   input  fsl_code_e fs_code,
   input  logic      fs_early,
   input  logic      fs_inv,
   output logic      tx_fs,
   output logic      rx_fs
);

   logic frame_on;
   logic pre_on;
   logic bit_sync;
   logic word_sync;

   assign frame_on = od_mode ? od_act  : 1'b1;
   assign pre_on   = od_mode ? od_pend : 1'b1;
   assign bit_sync = frame_last && pre_on;

   always_comb begin
      if (fs_early)
         word_sync = bit_sync || (slot0 && !last_bit && frame_on);
      else
         word_sync = slot0 && frame_on;
   end

   assign tx_fs = (tx_is_bit(fs_code) ? bit_sync : word_sync) ^ fs_inv;
   assign rx_fs = (rx_is_bit(fs_code) ? bit_sync : word_sync) ^ fs_inv;

endmodule

// File: rtl/tdm_slot_gate.sv
module tdm_slot_gate #(
   parameter int SLOT_W  = 5,
   parameter bit MASK_EN = 1'b1,
   localparam int N_SLOTS = 2 ** SLOT_W
) (
   input  logic [SLOT_W-1:0]  slot_cnt,
   input  logic [N_SLOTS-1:0] tx_mask,
   input  logic [N_SLOTS-1:0] rx_mask,
   input  logic               net_mode,
   input  logic               od_mode,
   input  logic               od_act,
   output logic               tx_slot_en,
   output logic               rx_slot_en
);

   logic [N_SLOTS-1:0] hit;
   logic               tx_sel;
   logic               rx_sel;

   for (genvar i = 0; i < N_SLOTS; i++) begin : g_dec
      assign hit[i] = (slot_cnt == SLOT_W'(i));
   end

   if (MASK_EN) begin : g_masked
      assign tx_sel = |(hit & tx_mask);
      assign rx_sel = |(hit & rx_mask);
   end else begin : g_open
      logic unused_masks;
      assign unused_masks = ^{tx_mask, rx_mask};
      assign tx_sel = 1'b1;
      assign rx_sel = 1'b1;
   end

   always_comb begin
      if (od_mode) begin
         tx_slot_en = od_act;
         rx_slot_en = od_act;
      end else if (net_mode) begin
         tx_slot_en = tx_sel;
         rx_slot_en = rx_sel;
      end else begin
         tx_slot_en = hit[0];
         rx_slot_en = hit[0];
      end
   end

endmodule

// File: rtl/tdm_slot_sequencer.sv
module tdm_slot_sequencer
   import tdm_seq_pkg::*;
#(
   parameter int WL_W    = 6,
   parameter int SLOT_W  = 5,
   parameter bit MASK_EN = 1'b1,
   localparam int N_SLOTS = 2 ** SLOT_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bit_en,
   input  logic [WL_W-1:0]    word_len,
   input  logic [SLOT_W-1:0]  rate_field,
   input  logic               net_mode,
   input  logic [1:0]         fs_len,
   input  logic               fs_early,
   input  logic               fs_inv,
   input  logic [N_SLOTS-1:0] tx_mask,
   input  logic [N_SLOTS-1:0] rx_mask,
   input  logic               tx_wr,
   input  logic               null_wr,
   output logic               tx_fs,
   output logic               rx_fs,
   output logic               word_start,
   output logic [SLOT_W-1:0]  slot_idx,
   output logic               tx_slot_en,
   output logic               rx_slot_en,
   output logic               tx_hiz,
   output logic               tx_urun_en,
   output logic               tx_last_slot,
   output logic               rx_last_slot
);

   if (WL_W < 2) begin : g_bad_wl
      $error("WL_W must be at least 2");
   end
   if (SLOT_W < 1 || SLOT_W > 8) begin : g_bad_slot
      $error("SLOT_W must be 1..8");
   end

   logic [WL_W-1:0]   bit_cnt;
   logic [SLOT_W-1:0] slot_cnt;
   logic              last_bit;
   logic              last_slot;
   logic              frame_last;
   logic              od_mode;
   logic              od_pend;
   logic              od_act;
   logic              null_flag;
   logic              slot0;
   logic              net_tdm;

   assign od_mode    = net_mode && (rate_field == '0);
   assign net_tdm    = net_mode && !od_mode;
   assign frame_last = last_bit && last_slot;
   assign slot0      = (slot_cnt == '0);

   tdm_bit_slot_counter #(.WL_W(WL_W), .SLOT_W(SLOT_W)) u_cnt (
      .clk          (clk),
      .rst_n        (rst_n),
      .bit_en       (bit_en),
      .word_len     (word_len),
      .slot_last_idx(rate_field),
      .bit_cnt      (bit_cnt),
      .slot_cnt     (slot_cnt),
      .last_bit     (last_bit),
      .last_slot    (last_slot)
   );

   tdm_frame_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_en    (bit_en),
      .od_mode   (od_mode),
      .frame_last(frame_last),
      .last_bit  (last_bit),
      .tx_wr     (tx_wr),
      .null_wr   (null_wr),
      .od_pend   (od_pend),
      .od_act    (od_act),
      .null_flag (null_flag)
   );

   tdm_sync_gen u_sync (
      .slot0     (slot0),
      .last_bit  (last_bit),
      .frame_last(frame_last),
      .od_mode   (od_mode),
      .od_pend   (od_pend),
      .od_act    (od_act),
      .fs_code   (fsl_code_e'(fs_len)),
      .fs_early  (fs_early),
      .fs_inv    (fs_inv),
      .tx_fs     (tx_fs),
      .rx_fs     (rx_fs)
   );

   tdm_slot_gate #(.SLOT_W(SLOT_W), .MASK_EN(MASK_EN)) u_gate (
      .slot_cnt  (slot_cnt),
      .tx_mask   (tx_mask),
      .rx_mask   (rx_mask),
      .net_mode  (net_mode),
      .od_mode   (od_mode),
      .od_act    (od_act),
      .tx_slot_en(tx_slot_en),
      .rx_slot_en(rx_slot_en)
   );

   assign slot_idx     = slot_cnt;
   assign word_start   = (bit_cnt == '0) && (od_mode ? od_act : 1'b1);
   assign tx_hiz       = !tx_slot_en || null_flag;
   assign tx_urun_en   = tx_slot_en && !od_mode;
   assign tx_last_slot = net_tdm && last_slot && (bit_cnt == '0);
   assign rx_last_slot = net_tdm && frame_last && bit_en;

endmodule

// File: rtl/tdm_seq_checker.sv
module tdm_seq_checker #(
   parameter int WL_W   = 6,
   parameter int SLOT_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bit_en,
   input logic              net_mode,
   input logic [SLOT_W-1:0] rate_field,
   input logic [WL_W-1:0]   word_len,
   input logic              null_wr,
   input logic              tx_slot_en,
   input logic              tx_hiz,
   input logic              tx_urun_en,
   input logic [SLOT_W-1:0] slot_idx,
   input logic              word_start,
   input logic              tx_last_slot,
   input logic              rx_last_slot
);

   p_od_no_urun_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (net_mode && rate_field == '0) |-> (!tx_urun_en && !tx_last_slot && !rx_last_slot));

   p_hiz_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_slot_en |-> tx_hiz);

   p_null_silences_r8: assert property (@(posedge clk) disable iff (!rst_n)
      null_wr |=> tx_hiz);

   p_last_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (word_len >= WL_W'(2)) |-> !(tx_last_slot && rx_last_slot));

   p_wrap_after_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rx_last_slot |=> (slot_idx == '0 && word_start));

   p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> $stable(slot_idx));

endmodule

bind tdm_slot_sequencer tdm_seq_checker #(.WL_W(WL_W), .SLOT_W(SLOT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bit_en      (bit_en),
   .net_mode    (net_mode),
   .rate_field  (rate_field),
   .word_len    (word_len),
   .null_wr     (null_wr),
   .tx_slot_en  (tx_slot_en),
   .tx_hiz      (tx_hiz),
   .tx_urun_en  (tx_urun_en),
   .slot_idx    (slot_idx),
   .word_start  (word_start),
   .tx_last_slot(tx_last_slot),
   .rx_last_slot(rx_last_slot)
);

// File: tb/tdm_slot_sequencer_tb.sv
module tdm_slot_sequencer_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bit_en = 1'b0;
   logic [5:0]  word_len = 6'd8;
   logic [4:0]  rate_field = 5'd3;
   logic        net_mode = 1'b0;
   logic [1:0]  fs_len = 2'd0;
   logic        fs_early = 1'b0;
   logic        fs_inv = 1'b0;
   logic [31:0] tx_mask = '1;
   logic [31:0] rx_mask = '1;
   logic        tx_wr = 1'b0;
   logic        null_wr = 1'b0;
   logic        tx_fs, rx_fs, word_start, tx_slot_en, rx_slot_en;
   logic        tx_hiz, tx_urun_en, tx_last_slot, rx_last_slot;
   logic [4:0]  slot_idx;

   int checks = 0;
   int fails  = 0;
   int pos    = 0;
   logic rx_seen;

   always #4 clk = ~clk;

   tdm_slot_sequencer dut_i (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .word_len(word_len),
      .rate_field(rate_field), .net_mode(net_mode), .fs_len(fs_len),
      .fs_early(fs_early), .fs_inv(fs_inv), .tx_mask(tx_mask), .rx_mask(rx_mask),
      .tx_wr(tx_wr), .null_wr(null_wr), .tx_fs(tx_fs), .rx_fs(rx_fs),
      .word_start(word_start), .slot_idx(slot_idx), .tx_slot_en(tx_slot_en),
      .rx_slot_en(rx_slot_en), .tx_hiz(tx_hiz), .tx_urun_en(tx_urun_en),
      .tx_last_slot(tx_last_slot), .rx_last_slot(rx_last_slot)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s pos=%0d actual=%0h expected=%0h", req, what, pos, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; bit_en = 1'b0; tx_wr = 1'b0; null_wr = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      pos = 0;
      #1;
   endtask

   task automatic tick();
      @(negedge clk);
      bit_en = 1'b1;
      #1 rx_seen = rx_last_slot;
      @(negedge clk);
      bit_en = 1'b0;
      #1;
   endtask

   // compares every output with the framing rules for a non-on-demand setup
   task automatic run_model(input string req, input int n);
      for (int k = 0; k < n; k++) begin
         int wl, nsl, bc, sc;
         logic lb, ls, fl, wsync, bsync, etx, erx, ten, ren;
         wl  = int'(word_len);
         nsl = int'(rate_field) + 1;
         bc  = pos % wl;
         sc  = (pos / wl) % nsl;
         lb  = (bc == wl - 1);
         ls  = (sc == nsl - 1);
         fl  = lb && ls;
         bsync = fl;
         wsync = fs_early ? (fl || (sc == 0 && !lb)) : (sc == 0);
         etx = ((fs_len == 2'd1 || fs_len == 2'd2) ? bsync : wsync) ^ fs_inv;
         erx = (fs_len[1] ? bsync : wsync) ^ fs_inv;
         ten = net_mode ? tx_mask[sc] : (sc == 0);
         ren = net_mode ? rx_mask[sc] : (sc == 0);
         chk(req, "tx_fs", int'(tx_fs), int'(etx));
         chk(req, "rx_fs", int'(rx_fs), int'(erx));
         chk(req, "slot_idx R10", int'(slot_idx), sc);
         chk(req, "word_start R11", int'(word_start), int'(bc == 0));
         chk(req, "tx_slot_en", int'(tx_slot_en), int'(ten));
         chk(req, "rx_slot_en", int'(rx_slot_en), int'(ren));
         chk(req, "tx_hiz R7", int'(tx_hiz), int'(!ten));
         chk(req, "tx_urun_en R7", int'(tx_urun_en), int'(ten));
         chk(req, "tx_last_slot R9", int'(tx_last_slot), int'(net_mode && ls && bc == 0));
         tick();
         chk(req, "rx_last_slot R9", int'(rx_seen), int'(net_mode && fl));
         pos++;
      end
   endtask

   task automatic cfg(input logic nm, input int rf, input int wl, input int fl,
                      input logic early, input logic inv);
      net_mode = nm; rate_field = 5'(rf); word_len = 6'(wl);
      fs_len = 2'(fl); fs_early = early; fs_inv = inv;
   endtask

   task automatic t_reset();
      cfg(1'b0, 3, 8, 0, 1'b0, 1'b0);
      tx_mask = '1; rx_mask = '1;
      do_reset();
      chk("R12", "slot_idx", int'(slot_idx), 0);
      chk("R12", "word_start", int'(word_start), 1);
      chk("R12", "tx_fs", int'(tx_fs), 1);
      chk("R12", "tx_hiz", int'(tx_hiz), 0);
      chk("R12", "tx_last_slot", int'(tx_last_slot), 0);
   endtask

   task automatic t_normal();
      cfg(1'b0, 3, 8, 0, 1'b0, 1'b0);
      tx_mask = '0; rx_mask = '0;   // ignored in normal mode
      do_reset();
      run_model("R1", 64);
      cfg(1'b0, 0, 12, 0, 1'b0, 1'b0);
      do_reset();
      run_model("R1", 26);
   endtask

   task automatic t_network();
      cfg(1'b1, 3, 8, 0, 1'b0, 1'b0);
      tx_mask = 32'h0000_0005; rx_mask = 32'h0000_0002;
      do_reset();
      run_model("R2", 70);
      cfg(1'b1, 31, 2, 2, 1'b0, 1'b0);
      tx_mask = 32'hA5A5_F00F; rx_mask = 32'h0FF0_3C5A;
      do_reset();
      run_model("R2", 132);
   endtask

   task automatic t_fslen();
      for (int c = 0; c < 4; c++) begin
         cfg(1'b0, 1, 8, c, 1'b0, 1'b0);
         tx_mask = '1; rx_mask = '1;
         do_reset();
         run_model("R4", 34);
      end
   endtask

   task automatic t_early();
      for (int c = 0; c < 4; c++) begin
         cfg(1'b0, 1, 8, c, 1'b1, 1'b0);
         do_reset();
         run_model("R5", 34);
      end
   endtask

   task automatic t_polarity();
      cfg(1'b0, 1, 8, 0, 1'b0, 1'b1);
      do_reset();
      run_model("R6", 34);
      cfg(1'b1, 2, 6, 2, 1'b0, 1'b1);
      do_reset();
      run_model("R6", 40);
   endtask

   task automatic t_hold();
      cfg(1'b1, 3, 8, 0, 1'b0, 1'b0);
      tx_mask = '1; rx_mask = '1;
      do_reset();
      for (int k = 0; k < 15; k++) tick();
      repeat (6) @(negedge clk);
      #1;
      chk("R10", "slot_idx held", int'(slot_idx), 1);
      tick();
      chk("R10", "slot_idx after 16 bits", int'(slot_idx), 2);
   endtask

   task automatic t_null();
      cfg(1'b1, 3, 8, 0, 1'b0, 1'b0);
      tx_mask = '1; rx_mask = '1;
      do_reset();
      for (int k = 0; k < 10; k++) tick();
      chk("R8", "tx_hiz before null", int'(tx_hiz), 0);
      @(negedge clk); null_wr = 1'b1;
      @(negedge clk); null_wr = 1'b0;
      #1;
      chk("R8", "tx_hiz after null", int'(tx_hiz), 1);
      chk("R8", "tx_slot_en unchanged", int'(tx_slot_en), 1);
      for (int k = 0; k < 5; k++) tick();
      chk("R8", "tx_hiz last bit of slot", int'(tx_hiz), 1);
      tick();
      chk("R8", "slot_idx next slot", int'(slot_idx), 2);
      chk("R8", "tx_hiz next slot", int'(tx_hiz), 0);
   endtask

   task automatic t_on_demand();
      cfg(1'b1, 0, 8, 0, 1'b0, 1'b0);
      tx_mask = '1; rx_mask = '1;
      do_reset();
      for (int k = 0; k < 12; k++) begin
         if (k == 0 || k == 11) begin
            chk("R3", "idle tx_fs", int'(tx_fs), 0);
            chk("R3", "idle rx_fs", int'(rx_fs), 0);
            chk("R3", "idle tx_hiz", int'(tx_hiz), 1);
            chk("R11", "idle word_start", int'(word_start), 0);
         end
         tick();
      end
      @(negedge clk); tx_wr = 1'b1;
      @(negedge clk); tx_wr = 1'b0;
      #1;
      chk("R3", "tx_fs waits for boundary", int'(tx_fs), 0);
      for (int k = 12; k < 16; k++) tick();
      chk("R3", "active tx_fs", int'(tx_fs), 1);
      chk("R3", "active tx_hiz", int'(tx_hiz), 0);
      chk("R3", "active rx_slot_en", int'(rx_slot_en), 1);
      chk("R3", "tx_urun_en off", int'(tx_urun_en), 0);
      chk("R11", "active word_start", int'(word_start), 1);
      tick();
      chk("R11", "word_start second bit", int'(word_start), 0);
      chk("R3", "tx_fs mid word", int'(tx_fs), 1);
      for (int k = 17; k < 24; k++) tick();
      chk("R3", "tx_fs after word", int'(tx_fs), 0);
      chk("R3", "tx_hiz after word", int'(tx_hiz), 1);
      chk("R9", "no last slot in on-demand", int'(tx_last_slot), 0);
   endtask

   task automatic finish_all();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      finish_all();
   end

   initial begin
      t_reset();
      t_normal();
      t_network();
      t_fslen();
      t_early();
      t_polarity();
      t_hold();
      t_null();
      t_on_demand();
      finish_all();
   end

endmodule